// File: doc/BRIEF.md
# SMBus Register-File Target

This block is a byte-oriented SMBus/I2C target that lets a bus host read and write a small bank of 8-bit registers. It watches the bus clock and data lines through two-flop synchronizers, detects START and STOP conditions, and pulls the data line low through an open-drain enable when it acknowledges or sends a zero. Its 7-bit device address is the constant binary prefix `10` followed by five strap inputs. After the address, a command byte picks one of eight registers through its three least significant bits.

Four transactions are supported: write byte, write word, read byte and read word. A read begins as a write of the command byte, then uses a repeated START and the same address with the read bit set. In a read word, the target sends the selected register twice. In a write word, the second byte goes to the next register index. The storage is also reachable from the rest of the chip through a parallel port with a registered read path.

Top module: `smb_regfile_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and all eight registers read as 0x00.
- R2: The target acknowledges (SDA low in the ninth clock) only an address equal to {2'b10, addr_strap}. On any other address, SDA stays released and every following byte is ignored, with no acknowledge and no register change, until the next START.
- R3: Only command bits [2:0] select the register. Command bits [7:3] have no effect.
- R4: A write byte stores the data byte in the selected register. The target acknowledges the address, the command and the data byte.
- R5: In a write word, the first data byte goes to the selected index and the second to index+1, wrapping from 7 to 0. Both data bytes are acknowledged.
- R6: A read (address with bit 0 = 0, command, repeated START, address with bit 0 = 1) returns the selected register MSB first. After the host NACKs, SDA is released.
- R7: If the host ACKs the first read byte, the second byte is the same register's value again.
- R8: `sda_oe` changes only while SCL is low. A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R9: A parallel write (`loc_we`) stores `loc_wdata` at `loc_idx`. `loc_rdata` shows the register at `loc_idx` one clock after it is presented, and the bus sees locally written values.
- R10: A START at any point, including in the middle of a byte, restarts address reception. The transaction that follows behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_strap | input | 5 | Low five bits of the device address |
| sda_oe | output | 1 | 1 pulls the data line low |
| loc_we | input | 1 | Parallel-port write strobe |
| loc_idx | input | 3 | Parallel-port register index |
| loc_wdata | input | 8 | Parallel-port write data |
| loc_rdata | output | 8 | Parallel-port read data, registered |

## Verification
The assertions assume a well-behaved host and a system clock much faster than SCL. Each SCL phase must last several system clocks, so the synchronizer delay ends before the next edge. The host must change SDA only while SCL is low, except when it makes a START or STOP, and it must never make a STOP while the target holds SDA low. The bench host holds every quarter of an SCL period for six clocks. It changes SDA only in the low phase, or for START and STOP. It sends a STOP only after a NACK or after a byte that the target has finished acknowledging, so the stimulus stays within these assumptions.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_widx,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_ridx,
  output logic [DW-1:0] bus_rdata,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_idx,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      loc_rdata <= '0;
    end else begin
      if (loc_we && !(bus_we && bus_widx == loc_idx)) mem[loc_idx] <= loc_wdata;
      if (bus_we) mem[bus_widx] <= bus_wdata;
      loc_rdata <= mem[loc_idx];
    end
  end

  assign bus_rdata = mem[bus_ridx];
endmodule

// File: rtl/smb_target_ctrl.sv
module smb_target_ctrl
  import smb_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         AW       = 3,
  parameter int         STRAP_W  = 5,
  parameter logic [1:0] ADDR_FIX = 2'b10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic               wr_en,
  output logic [AW-1:0]      wr_idx,
  output logic [DW-1:0]      wr_data,
  output logic [AW-1:0]      ptr,
  output logic               sda_oe,
  output smb_state_e         state
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx;
  logic          rw, host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt <= '0;
      sh <= '0;
      tx <= '0;
      rw <= 1'b0;
      host_ack <= 1'b0;
      ptr <= '0;
      sda_oe <= 1'b0;
      wr_en <= 1'b0;
      wr_idx <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[DW-1:1] == {ADDR_FIX, strap}) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                ptr    <= sh[AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_CMD_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= sh;
                ptr     <= ptr + 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= {rd_data[DW-2:0], 1'b0};
              sda_oe <= ~rd_data[DW-1];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
          ST_CMD_ACK, ST_WDATA_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                state  <= ST_RDATA_ACK;
              end else begin
                sda_oe <= ~tx[DW-1];
                tx     <= {tx[DW-2:0], 1'b0};
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx     <= {rd_data[DW-2:0], 1'b0};
                sda_oe <= ~rd_data[DW-1];
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regfile_target.sv
module smb_regfile_target
  import smb_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         AW          = 3,
  parameter int         STRAP_W     = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] ADDR_FIX    = 2'b10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic               sda_oe,
  input  logic               loc_we,
  input  logic [AW-1:0]      loc_idx,
  input  logic [DW-1:0]      loc_wdata,
  output logic [DW-1:0]      loc_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0] wr_idx, ptr;
  logic [DW-1:0] wr_data, rd_data;
  smb_state_e state;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_target_ctrl #(.DW(DW), .AW(AW), .STRAP_W(STRAP_W), .ADDR_FIX(ADDR_FIX)) u_ctrl (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap(addr_strap), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ptr(ptr), .sda_oe(sda_oe), .state(state)
  );

  smb_regbank #(.DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .bus_we(wr_en), .bus_widx(wr_idx), .bus_wdata(wr_data),
    .bus_ridx(ptr), .bus_rdata(rd_data), .loc_we(loc_we), .loc_idx(loc_idx),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );
endmodule

// File: rtl/smb_regfile_target_chk.sv
module smb_regfile_target_chk
  import smb_pkg::*;
#(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input logic [AW-1:0] ptr,
  input smb_state_e    state
);
  assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !sda_oe);

  assert_start_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> state == ST_ADDR);

  assert_read_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RDATA || state == ST_RDATA_ACK) &&
     ($past(state) == ST_RDATA || $past(state) == ST_RDATA_ACK)) |-> $stable(ptr));
endmodule

bind smb_regfile_target smb_regfile_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .start_det(start_det),
  .stop_det(stop_det), .ptr(ptr), .state(state)
);

// File: tb/smb_regfile_target_tb.sv
module smb_regfile_target_tb;
  localparam int HQ = 6;
  localparam logic [4:0] STRAP = 5'b10110;
  localparam logic [6:0] DEV = {2'b10, STRAP};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe;
  logic loc_we = 1'b0;
  logic [2:0] loc_idx = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  wire  sda_line = ~(sda_oe | host_low);

  int n_cmp = 0, n_bad = 0, viol = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  smb_regfile_target u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .addr_strap(STRAP),
    .sda_oe(sda_oe), .loc_we(loc_we), .loc_idx(loc_idx), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst && scl && scl_prev && sda_oe != oe_prev) viol++;
    oe_prev  <= sda_oe;
    scl_prev <= scl;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic drv, output logic smp);
    host_low = ~drv; wait_c(HQ);
    scl = 1'b1; wait_c(HQ);
    smp = sda_line; wait_c(HQ);
    scl = 1'b0; wait_c(HQ);
  endtask

  task automatic bus_start();
    host_low = 1'b0; wait_c(HQ);
    scl = 1'b1; wait_c(HQ);
    host_low = 1'b1; wait_c(HQ);
    scl = 1'b0; wait_c(HQ);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; wait_c(HQ);
    scl = 1'b1; wait_c(HQ);
    host_low = 1'b0; wait_c(2 * HQ);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d0,
                           input logic [7:0] d1, input int nb, output logic [3:0] acks);
    acks = '0;
    bus_start();
    send_byte({a, 1'b0}, acks[0]);
    send_byte(cmd, acks[1]);
    send_byte(d0, acks[2]);
    if (nb == 2) send_byte(d1, acks[3]);
    bus_stop();
  endtask

  task automatic bus_read(input logic [7:0] cmd, input int nb,
                          output logic [7:0] r0, output logic [7:0] r1, output logic [2:0] acks);
    bus_start();
    send_byte({DEV, 1'b0}, acks[0]);
    send_byte(cmd, acks[1]);
    bus_start();
    send_byte({DEV, 1'b1}, acks[2]);
    recv_byte(nb == 2, r0);
    r1 = '0;
    if (nb == 2) recv_byte(1'b0, r1);
    bus_stop();
  endtask

  task automatic loc_read(input logic [2:0] idx, output logic [7:0] v);
    loc_idx = idx;
    wait_c(2);
    v = loc_rdata;
  endtask

  task automatic check_all_regs(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      loc_read(3'(i), v);
      check(tag, v, model[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] wa;
    logic [2:0] ra;
    logic [7:0] r0, r1, cmd;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    wait_c(5);
    rst = 1'b0;
    wait_c(2);

    // R1: reset state
    check("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
    check_all_regs("R1 reg reset");

    // R4 and R3: write byte sweep with junk in the upper command bits
    for (int i = 0; i < 8; i++) begin
      cmd = {5'(i * 3 + 17), 3'(i)};
      bus_write(DEV, cmd, 8'(i * 37 + 11), 8'h00, 1, wa);
      model[i] = 8'(i * 37 + 11);
      check("R4 acks", {5'b0, wa[2:0]}, 8'h07);
      check("R8 released after stop", {7'b0, sda_oe}, 8'h00);
    end
    check_all_regs("R3 R4 stored");

    // R6: read byte sweep
    for (int i = 0; i < 8; i++) begin
      cmd = {5'(i * 5 + 9), 3'(i)};
      bus_read(cmd, 1, r0, r1, ra);
      check("R6 acks", {5'b0, ra}, 8'h07);
      check("R6 read byte", r0, model[i]);
      check("R6 released", {7'b0, sda_oe}, 8'h00);
    end

    // R5: write word, including the wrap from 7 to 0
    bus_write(DEV, 8'h03, 8'hA5, 8'h5A, 2, wa);
    model[3] = 8'hA5; model[4] = 8'h5A;
    check("R5 acks", {4'b0, wa}, 8'h0F);
    bus_write(DEV, 8'hFF, 8'hC3, 8'h3C, 2, wa);
    model[7] = 8'hC3; model[0] = 8'h3C;
    check("R5 wrap acks", {4'b0, wa}, 8'h0F);
    check_all_regs("R5 word stored");

    // R7: read word repeats the same register
    for (int i = 0; i < 8; i += 3) begin
      bus_read(8'(i), 2, r0, r1, ra);
      check("R7 first", r0, model[i]);
      check("R7 second", r1, model[i]);
    end

    // R2: wrong strap bit and wrong fixed bits are ignored
    bus_write(DEV ^ 7'h01, 8'h01, 8'hEE, 8'hDD, 2, wa);
    check("R2 strap mismatch nack", {4'b0, wa}, 8'h00);
    bus_write({2'b01, STRAP}, 8'h02, 8'hEE, 8'hDD, 2, wa);
    check("R2 fixed mismatch nack", {4'b0, wa}, 8'h00);
    check_all_regs("R2 unchanged");

    // R9: parallel-port write, then read over the bus
    loc_idx = 3'd6; loc_wdata = 8'h96; loc_we = 1'b1;
    wait_c(1);
    loc_we = 1'b0;
    model[6] = 8'h96;
    loc_read(3'd6, r0);
    check("R9 local readback", r0, 8'h96);
    bus_read(8'h06, 1, r0, r1, ra);
    check("R9 bus sees local", r0, 8'h96);

    // R10: START in the middle of a command byte
    bus_start();
    send_byte({DEV, 1'b0}, wa[0]);
    clk_bit(1'b1, wa[1]);
    clk_bit(1'b0, wa[1]);
    clk_bit(1'b1, wa[1]);
    bus_write(DEV, 8'h02, 8'h71, 8'h00, 1, wa);
    model[2] = 8'h71;
    check("R10 acks after restart", {5'b0, wa[2:0]}, 8'h07);
    check_all_regs("R10 stored");

    check("R8 sda_oe changes only with SCL low", 8'(viol), 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule